// File: doc/BRIEF.md
# Dual External-Event Time Capture

This block records the system time when an external event occurs. It has two capture channels, each fed by an asynchronous input pin. Channel 0 is the slave-side event input and channel 1 is the master-side event input. A pin is first brought into the clock domain, and its rising edge then latches the current value of the 64-bit system-time bus into that channel's snapshot register. The time value is counted in 32 ns ticks and arrives from an external time counter.

Each capture raises a pending flag in a shared event word. The interrupt line goes high while any pending flag is set and its mask bit in the control word is clear. A snapshot stays frozen while its flag is pending, so software can read the high word and then the low word and get a consistent pair. Software then clears the flag by writing a 1 to its bit. An edge that arrives while the flag is still pending is not captured; it sets an overrun bit instead.

Top module: `aux_snap_unit`

## Requirements
- R1: After a synchronous reset, the control word, the event word and all four snapshot words read 0, and `irq` is low.
- R2: A pin that rises and stays high is captured at the third rising clock edge after the change. The snapshot holds the `sys_time` value present at that edge. A pin held high produces exactly one capture.
- R3: Word address 1 is the event word. Bit 2 is the channel 0 (slave-side) pending flag and bit 3 is the channel 1 (master-side) pending flag. The snapshot words sit at these addresses: address 2 for channel 0 low, 3 for channel 0 high, 4 for channel 1 low and 5 for channel 1 high. A low word is bits 31:0 of the time and a high word is bits 63:32.
- R4: Writing the event word clears each pending flag whose data bit is 1. A flag whose data bit is 0 keeps its value.
- R5: While a channel's flag is pending, a new rising edge leaves its snapshot unchanged. The edge sets that channel's overrun bit instead: bit 4 of the event word for channel 0 and bit 5 for channel 1.
- R6: When a capture and a clear of the same flag fall in the same cycle, the flag stays set, the new time is captured and no overrun is recorded.
- R7: Word address 0 is the control word. Bit 2 masks channel 0 and bit 3 masks channel 1, and both read back. `irq` is high exactly when some pending flag is set and its mask bit is 0.
- R8: Overrun bits clear when a 1 is written to their event-word bit. They never drive `irq`.
- R9: The two channels are independent. A capture, clear or overrun on one channel leaves the other channel's flag and snapshot unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_time | input | 64 | System time in 32 ns ticks |
| evt_slv_pin | input | 1 | Asynchronous slave-side event input (channel 0) |
| evt_mst_pin | input | 1 | Asynchronous master-side event input (channel 1) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Unmasked pending-capture interrupt |

## Verification
The assertions assume that each event pin holds a level for at least one clock period. They also assume that `sys_time` is a clean synchronous bus, so a captured value equals the value on the bus at the capture edge. The stimulus keeps each pin level for several cycles and holds `sys_time` constant across every capture window. It places register writes on the falling edge, so each write is seen at exactly one rising edge, including the one write that is deliberately aligned with a capture edge.

// File: rtl/aux_snap_pkg.sv
package aux_snap_pkg;

    localparam int ADDR_W   = 3;
    localparam int N_CH     = 2;
    localparam int PEND_LSB = 2;
    localparam int OVR_LSB  = 4;
    localparam int MASK_LSB = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_EVENT = 3'd1,
        A_C0_LO = 3'd2,
        A_C0_HI = 3'd3,
        A_C1_LO = 3'd4,
        A_C1_HI = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic pend;
        logic ovr;
    } chan_flags_t;

    function automatic logic [ADDR_W-1:0] lo_addr(input int ch);
        return ADDR_W'(2 + 2 * ch);
    endfunction

endpackage

// File: rtl/aux_edge_sync.sv
module aux_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic [STAGES-1:0] sr;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            prev <= 1'b0;
        end else begin
            sr   <= {sr[STAGES-2:0], pin};
            prev <= sr[STAGES-1];
        end
    end

    assign rise = sr[STAGES-1] & ~prev;

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/aux_snap_chan.sv
module aux_snap_chan
    import aux_snap_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic [TIME_W-1:0] sys_time,
    input  logic              clr_pend,
    input  logic              clr_ovr,
    output logic [TIME_W-1:0] snap,
    output chan_flags_t       flags
);
    logic take;
    assign take = rise && (!flags.pend || clr_pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap  <= '0;
            flags <= '0;
        end else begin
            if (take) begin
                snap       <= sys_time;
                flags.pend <= 1'b1;
            end else if (clr_pend) begin
                flags.pend <= 1'b0;
            end
            if (rise && flags.pend && !clr_pend) begin
                flags.ovr <= 1'b1;
            end else if (clr_ovr) begin
                flags.ovr <= 1'b0;
            end
        end
    end

    // R2
    capture_value_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && !flags.pend) |=> (flags.pend && snap == $past(sys_time)));

    // R5
    hold_snapshot_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.pend && !clr_pend) |=> $stable(snap));

    // R5
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && flags.pend && !clr_pend) |=> flags.ovr);

    // R4
    clear_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_pend && !rise) |=> !flags.pend);

    // R6
    clear_race_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_pend && rise) |=> (flags.pend && snap == $past(sys_time)));

endmodule

// File: rtl/aux_snap_unit.sv
module aux_snap_unit
    import aux_snap_pkg::*;
#(
    parameter int TIME_W      = 64,
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] sys_time,
    input  logic              evt_slv_pin,
    input  logic              evt_mst_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq
);
    localparam int HI_W = TIME_W - WORD_W;

    logic [N_CH-1:0]   pins;
    logic [N_CH-1:0]   rise;
    logic [N_CH-1:0]   clr_pend;
    logic [N_CH-1:0]   clr_ovr;
    logic [N_CH-1:0]   pend_v;
    logic [N_CH-1:0]   ovr_v;
    logic [N_CH-1:0]   mask_q;
    logic [TIME_W-1:0] snap [N_CH];
    chan_flags_t       flags [N_CH];
    logic              ev_wr;

    assign pins  = {evt_mst_pin, evt_slv_pin};
    assign ev_wr = wr_en && (wr_addr == A_EVENT);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        aux_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk (clk),
            .rst (rst),
            .pin (pins[c]),
            .rise(rise[c])
        );

        assign clr_pend[c] = ev_wr && wr_data[PEND_LSB + c];
        assign clr_ovr[c]  = ev_wr && wr_data[OVR_LSB + c];

        aux_snap_chan #(.TIME_W(TIME_W)) chan_i (
            .clk     (clk),
            .rst     (rst),
            .rise    (rise[c]),
            .sys_time(sys_time),
            .clr_pend(clr_pend[c]),
            .clr_ovr (clr_ovr[c]),
            .snap    (snap[c]),
            .flags   (flags[c])
        );

        assign pend_v[c] = flags[c].pend;
        assign ovr_v[c]  = flags[c].ovr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en && wr_addr == A_CTRL) begin
            mask_q <= wr_data[MASK_LSB +: N_CH];
        end
    end

    assign irq = |(pend_v & ~mask_q);

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data[MASK_LSB +: N_CH] = mask_q;
            A_EVENT: begin
                rd_data[PEND_LSB +: N_CH] = pend_v;
                rd_data[OVR_LSB  +: N_CH] = ovr_v;
            end
            A_C0_LO: rd_data = snap[0][WORD_W-1:0];
            A_C0_HI: rd_data = WORD_W'(snap[0][TIME_W-1 -: HI_W]);
            A_C1_LO: rd_data = snap[1][WORD_W-1:0];
            A_C1_HI: rd_data = WORD_W'(snap[1][TIME_W-1 -: HI_W]);
            default: rd_data = '0;
        endcase
    end

    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_wr && (&wr_data[PEND_LSB +: N_CH]) && rise == '0) |=> !irq);

    // R9
    chan_isolation_chk: assert property (@(posedge clk) disable iff (rst)
        (!rise[1] && !clr_pend[1] && rise[0]) |=> $stable(snap[1]));

endmodule

// File: tb/aux_snap_unit_tb_top.sv
module aux_snap_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] sys_time = '0;
    logic        evt_slv_pin = 1'b0;
    logic        evt_mst_pin = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    logic [63:0] m_snap [2];
    logic        m_pend [2];
    logic        m_ovr  [2];
    logic [1:0]  m_mask;

    always #5 clk = ~clk;

    aux_snap_unit dut_i (
        .clk(clk), .rst(rst), .sys_time(sys_time),
        .evt_slv_pin(evt_slv_pin), .evt_mst_pin(evt_mst_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [31:0] exp_event();
        return {26'd0, m_ovr[1], m_ovr[0], m_pend[1], m_pend[0], 2'b00};
    endfunction

    function automatic logic exp_irq();
        return (m_pend[0] && !m_mask[0]) || (m_pend[1] && !m_mask[1]);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_pin(input int ch, input logic v);
        if (ch == 0) evt_slv_pin = v; else evt_mst_pin = v;
    endtask

    task automatic pulse(input int ch, input logic [63:0] t);
        @(negedge clk);
        sys_time = t;
        set_pin(ch, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        set_pin(ch, 1'b0);
        repeat (3) @(negedge clk);
    endtask

    task automatic model_edge(input int ch, input logic [63:0] t);
        if (m_pend[ch]) m_ovr[ch] = 1'b1;
        else begin m_snap[ch] = t; m_pend[ch] = 1'b1; end
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v, hi;
        @(negedge clk);
        rd(3'd1, v); chk({tag, " event"}, {32'd0, v}, {32'd0, exp_event()});
        for (int c = 0; c < 2; c++) begin
            rd(3'(3 + 2 * c), hi);
            rd(3'(2 + 2 * c), v);
            chk({tag, " snap"}, {hi, v}, m_snap[c]);
        end
        chk({tag, " irq"}, {63'd0, irq}, {63'd0, exp_irq()});
    endtask

    initial begin
        #500000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd77));
        for (int c = 0; c < 2; c++) begin
            m_snap[c] = '0; m_pend[c] = 1'b0; m_ovr[c] = 1'b0;
        end
        m_mask = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v); chk("R1 reset word", {32'd0, v}, 64'd0);
        end
        chk("R1 irq", {63'd0, irq}, 64'd0);

        // R2 capture timing: not yet after two edges, captured at third
        @(negedge clk);
        sys_time = 64'h0123_4567_89AB_CDEF;
        evt_slv_pin = 1'b1;
        repeat (2) @(posedge clk);
        #1 rd(3'd1, v); chk("R2 not before third edge", {32'd0, v}, 64'd0);
        @(posedge clk);
        #1 rd(3'd1, v); chk("R3 slave pending bit2", {32'd0, v}, 64'h4);
        model_edge(0, sys_time);
        // R2 level held: clear, wait, no second capture
        wr(3'd1, 32'h4); m_pend[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(3'd1, v); chk("R2 level held single capture", {32'd0, v}, 64'd0);
        evt_slv_pin = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R3 slave snapshot");

        // R3 master channel, R9 independence
        pulse(1, 64'hFEDC_BA98_7654_3210); model_edge(1, 64'hFEDC_BA98_7654_3210);
        check_all("R9 master independent");

        // R5 overrun on master, R4 write-zero keeps flag
        pulse(1, 64'h1111_2222_3333_4444); model_edge(1, 64'h1111_2222_3333_4444);
        wr(3'd1, 32'h0);
        check_all("R5 overrun hold / R4 zero write");

        // R8 overrun clear, pending kept
        wr(3'd1, 32'h20); m_ovr[1] = 1'b0;
        check_all("R8 overrun clear");

        // R7 mask
        wr(3'd0, 32'h8); m_mask = 2'b10;
        rd(3'd0, v); chk("R7 ctrl readback", {32'd0, v}, 64'h8);
        check_all("R7 masked irq");
        wr(3'd0, 32'h0); m_mask = 2'b00;
        check_all("R7 unmasked irq");

        // R6 same-cycle capture and clear on master (pending set)
        @(negedge clk);
        sys_time = 64'hAAAA_5555_0000_9999;
        evt_mst_pin = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'h8;
        @(negedge clk);
        wr_en = 1'b0;
        evt_mst_pin = 1'b0;
        m_snap[1] = 64'hAAAA_5555_0000_9999; m_pend[1] = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R6 clear race");

        // clear all before random phase
        wr(3'd1, 32'h3C);
        for (int c = 0; c < 2; c++) begin m_pend[c] = 1'b0; m_ovr[c] = 1'b0; end

        // random phase: R4 R5 R7 R9
        for (int i = 0; i < 24; i++) begin
            int ch;
            logic [63:0] t;
            logic [31:0] clr;
            ch = int'($urandom_range(0, 1));
            t = {$urandom, $urandom};
            clr = $urandom & 32'h3C;
            wr(3'd1, clr);
            for (int c = 0; c < 2; c++) begin
                if (clr[2 + c]) m_pend[c] = 1'b0;
                if (clr[4 + c]) m_ovr[c] = 1'b0;
            end
            m_mask = 2'($urandom);
            wr(3'd0, {28'd0, m_mask, 2'b00});
            pulse(ch, t); model_edge(ch, t);
            check_all("R4/R5/R7/R9 random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule